// File: doc/BRIEF.md
# Periodic interrupt rate divider

This block divides a 32.768 kHz timebase into one of fifteen periodic rates. Its clock input is the timebase itself, so one clock cycle is one timebase period. A 15-bit prescaler counts those cycles. A 4-bit rate code picks one tap of the prescaler. That tap drives two things: a one-clock periodic tick that goes to the interrupt flag logic, and a 50% duty square-wave pin. The same prescaler wraps once every 32768 cycles and gives the one-second tick used by the timekeeping logic.

A 3-bit divider-control field decides whether the prescaler runs. The value 010 selects the 32.768 kHz reference and lets the chain count. The values 110 and 111 hold the whole chain cleared. Any other value stops the count where it is. The square-wave enable gates the pin. The periodic-interrupt enable only gates a separate request output, so the tick itself always reaches the flag logic.

Top module: `pi_rate_div`

## Requirements
- R1: While reset is asserted and just after it is released, tick_o, per_irq_o, sqw_o and sec_o are all low.
- R2: With div_ctl_i = 010 and a rate code c from 3 to 15, tick_o pulses high for exactly one cycle every 2^(c-1) cycles, which is 32768 >> (c-1) Hz.
- R3: Rate code 1 gives one tick every 128 cycles (256 Hz), and rate code 2 gives one tick every 256 cycles (128 Hz).
- R4: Rate code 0 gives no tick and keeps sqw_o low.
- R5: With sqwe_i = 1 and a nonzero rate code, sqw_o is high for exactly half of each tick period. With sqwe_i = 0, sqw_o stays low.
- R6: With div_ctl_i = 110 or 111, the prescaler is held at zero, so there are no ticks and sqw_o is low. Any value other than 010, 110 or 111 freezes the prescaler: no ticks, no second tick, and sqw_o keeps its level.
- R7: After div_ctl_i changes from a hold value to 010, sec_o pulses for one cycle exactly 32768 cycles later, and again every 32768 cycles after that.
- R8: tick_o pulses whatever the value of pie_i. per_irq_o is high in exactly the cycles where tick_o and pie_i are both high.
- R9: With sqwe_i = 1, every tick_o pulse falls in the first cycle in which sqw_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz timebase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_ctl_i | input | 3 | Divider control: 010 runs, 110/111 hold cleared, other values freeze |
| rate_i | input | 4 | Periodic rate code; 0 turns the output off |
| sqwe_i | input | 1 | Square-wave pin enable |
| pie_i | input | 1 | Periodic interrupt enable |
| tick_o | output | 1 | One-cycle pulse at each rising edge of the selected rate |
| per_irq_o | output | 1 | tick_o gated by pie_i |
| sqw_o | output | 1 | 50% duty square wave at the selected rate |
| sec_o | output | 1 | One-cycle pulse once every 32768 cycles |

## Verification
The tap-alignment assertions assume that rate_i and sqwe_i stay stable for a cycle around each tick. A code change in the middle of a period can shift the tap phase, so a single tick is not checked while the code is changing. The bench changes the rate code, the enables and div_ctl_i only at falling edges. After each change of code it waits for a complete clean period before it measures. Counts and levels are sampled at falling edges, half a cycle after the registers update.

// File: rtl/pi_rate_pkg.sv
package pi_rate_pkg;
  localparam int RATE_W = 4;
  localparam int DIV_W  = 3;
  localparam logic [DIV_W-1:0] DIV_RUN = 3'b010;

  typedef logic [RATE_W-1:0] rate_t;

  // prescaler bit whose period matches the rate code
  function automatic logic [3:0] tap_of(rate_t code);
    case (code)
      4'd0:    tap_of = 4'd0;
      4'd1:    tap_of = 4'd6;
      4'd2:    tap_of = 4'd7;
      default: tap_of = code - 4'd2;
    endcase
  endfunction
endpackage

// File: rtl/pi_prescaler.sv
module pi_prescaler
  import pi_rate_pkg::*;
#(
  parameter int PRESC_W = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   div_ctl_i,
  output logic [PRESC_W-1:0] cnt_o,
  output logic               adv_o,
  output logic               sec_o
);
  localparam logic [PRESC_W-1:0] CNT_MAX = '1;

  logic [PRESC_W-1:0] cnt_q;
  logic adv_q, sec_q;
  logic run_w, hold_w;

  assign run_w  = (div_ctl_i == DIV_RUN);
  assign hold_w = (div_ctl_i[2:1] == 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      adv_q <= 1'b0;
      sec_q <= 1'b0;
    end else if (hold_w) begin
      cnt_q <= '0;
      adv_q <= 1'b0;
      sec_q <= 1'b0;
    end else begin
      adv_q <= run_w;
      sec_q <= run_w && (cnt_q == CNT_MAX);
      if (run_w) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign adv_o = adv_q;
  assign sec_o = sec_q;

  assert_hold_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_w |=> (cnt_q == '0) && !sec_q);
  assert_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_w && !hold_w) |=> $stable(cnt_q) && !sec_q);
  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q |-> (cnt_q == '0));
endmodule

// File: rtl/pi_rate_tap.sv
module pi_rate_tap
  import pi_rate_pkg::*;
#(
  parameter int PRESC_W = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] cnt_i,
  input  logic               adv_i,
  input  rate_t              rate_i,
  input  logic               sqwe_i,
  output logic               tick_o,
  output logic               sqw_o
);
  logic [3:0]         k_w;
  logic [PRESC_W-1:0] one_hot_w, mask_w;
  logic               on_w, tap_bit_w;

  assign on_w      = (rate_i != '0);
  assign k_w       = tap_of(rate_i);
  assign one_hot_w = PRESC_W'(1) << k_w;
  assign mask_w    = (one_hot_w << 1) - PRESC_W'(1);
  assign tap_bit_w = |(cnt_i & one_hot_w);

  // tick fires in the first cycle the tap bit is set after an advance
  assign tick_o = adv_i && on_w && ((cnt_i & mask_w) == one_hot_w);
  assign sqw_o  = sqwe_i && on_w && tap_bit_w;

  assert_tick_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $stable(rate_i)) |-> $rose(tap_bit_w));
endmodule

// File: rtl/pi_rate_div.sv
module pi_rate_div
  import pi_rate_pkg::*;
#(
  parameter int PRESC_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_ctl_i,
  input  logic [3:0]       rate_i,
  input  logic             sqwe_i,
  input  logic             pie_i,
  output logic             tick_o,
  output logic             per_irq_o,
  output logic             sqw_o,
  output logic             sec_o
);
  logic [PRESC_W-1:0] cnt_w;
  logic               adv_w;

  pi_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_ctl_i (div_ctl_i),
    .cnt_o     (cnt_w),
    .adv_o     (adv_w),
    .sec_o     (sec_o)
  );

  pi_rate_tap #(.PRESC_W(PRESC_W)) u_tap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt_w),
    .adv_i  (adv_w),
    .rate_i (rate_i),
    .sqwe_i (sqwe_i),
    .tick_o (tick_o),
    .sqw_o  (sqw_o)
  );

  assign per_irq_o = tick_o && pie_i;

  assert_sqw_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sqwe_i && $stable(sqwe_i) && $stable(rate_i)) |-> $rose(sqw_o));
endmodule

// File: tb/pi_rate_div_bench.sv
module pi_rate_div_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] div_ctl = 3'b110;
  logic [3:0] rate = 4'd0;
  logic sqwe = 1'b0, pie = 1'b0;
  logic tick, per_irq, sqw, sec;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pi_rate_div u_pi_rate_div (
    .clk_i(clk), .rst_ni(rst_n), .div_ctl_i(div_ctl), .rate_i(rate),
    .sqwe_i(sqwe), .pie_i(pie), .tick_o(tick), .per_irq_o(per_irq),
    .sqw_o(sqw), .sec_o(sec)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output bit ok);
    ok = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (tick) begin ok = 1; break; end
    end
  endtask

  task automatic t_reset;
    chk("R1 tick", tick, 0); chk("R1 sqw", sqw, 0);
    chk("R1 sec", sec, 0);   chk("R1 irq", per_irq, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post tick", tick, 0); chk("R1 post sqw", sqw, 0); chk("R1 post sec", sec, 0);
  endtask

  task automatic t_rate(input int code);
    int exp_p, p, hi, wide; bit ok;
    exp_p = (code == 1) ? 128 : (code == 2) ? 256 : (1 << (code - 1));
    @(negedge clk); div_ctl = 3'b010; rate = code[3:0]; sqwe = 1'b1;
    wait_tick(ok); wait_tick(ok);
    p = 0; hi = 0; wide = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk); p++;
      if (sqw) hi++;
      if (tick) break;
      if (p == 1 && tick) wide++;
    end
    if (code < 3) chk($sformatf("R3 period code %0d", code), p, exp_p);
    else          chk($sformatf("R2 period code %0d", code), p, exp_p);
    chk($sformatf("R5 duty code %0d", code), hi, exp_p / 2);
    chk("R9 sqw high at tick", sqw, 1);
    @(negedge clk);
    chk("R2 one-cycle tick", tick, (exp_p == 1) ? 1 : 0);
  endtask

  task automatic t_code0;
    int ticks = 0, hi = 0;
    @(negedge clk); rate = 4'd0; sqwe = 1'b1; div_ctl = 3'b010;
    repeat (600) begin @(negedge clk); ticks += tick; hi += sqw; end
    chk("R4 no tick", ticks, 0); chk("R4 sqw low", hi, 0);
  endtask

  task automatic t_enables;
    int ticks = 0, hi = 0, irqs = 0, mism = 0;
    @(negedge clk); rate = 4'd3; sqwe = 1'b0; pie = 1'b0;
    repeat (64) begin @(negedge clk); ticks += tick; hi += sqw; irqs += per_irq; end
    chk("R5 sqw off", hi, 0); chk("R8 tick w/o pie", ticks, 16); chk("R8 irq gated", irqs, 0);
    @(negedge clk); pie = 1'b1; ticks = 0;
    repeat (64) begin @(negedge clk); ticks += tick; if (per_irq != tick) mism++; end
    chk("R8 irq follows tick", mism, 0); chk("R8 ticks with pie", ticks, 16);
  endtask

  task automatic t_hold_freeze;
    int ticks = 0, hi = 0, chg = 0, secs = 0; logic lvl;
    @(negedge clk); rate = 4'd3; sqwe = 1'b1; div_ctl = 3'b110;
    repeat (40) begin @(negedge clk); ticks += tick; hi += sqw; end
    @(negedge clk); div_ctl = 3'b111;
    repeat (40) begin @(negedge clk); ticks += tick; hi += sqw; end
    chk("R6 hold ticks", ticks, 0); chk("R6 hold sqw", hi, 0);
    @(negedge clk); div_ctl = 3'b010;
    repeat (3) @(negedge clk);
    div_ctl = 3'b000; ticks = 0;
    @(negedge clk); lvl = sqw;
    chk("R6 freeze level", lvl, 1);
    repeat (50) begin @(negedge clk); ticks += tick; secs += sec; if (sqw != lvl) chg++; end
    chk("R6 freeze ticks", ticks, 0); chk("R6 freeze sqw stable", chg, 0); chk("R6 freeze sec", secs, 0);
  endtask

  task automatic t_second;
    int early = 0;
    @(negedge clk); div_ctl = 3'b110; rate = 4'd0;
    repeat (3) @(negedge clk);
    div_ctl = 3'b010;
    for (int n = 1; n < 32768; n++) begin @(negedge clk); early += sec; end
    chk("R7 no early sec", early, 0);
    @(negedge clk); chk("R7 first sec at 32768", sec, 1);
    @(negedge clk); chk("R7 sec one cycle", sec, 0);
    early = 0;
    for (int n = 2; n < 32768; n++) begin @(negedge clk); early += sec; end
    chk("R7 no sec between", early, 0);
    @(negedge clk); chk("R7 second sec", sec, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    for (int c = 1; c <= 12; c++) t_rate(c);
    t_rate(15);
    t_code0();
    t_enables();
    t_hold_freeze();
    t_second();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (195000) @(posedge clk); n_chk++; n_bad++; $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule